// File: doc/BRIEF.md
# Pin Event Interrupt Detector

This block watches twelve general-purpose input pins and turns activity on them into a single active-high interrupt for a parent interrupt controller. Each pin passes through a two-flop synchronizer. It is then tested against a trigger condition chosen per pin: a falling edge, a rising edge, either edge, a low level or a high level. A matching event on an enabled pin sets that pin's sticky status bit. The interrupt output is asserted while any pin has status set, is enabled and is not masked.

Firmware drives the block through a small word-addressed register bus (address, write strobe, write data, combinational read data). It can enable pins, read and clear the status, mask and unmask pins with separate write-one registers, and program each pin's trigger mode through two mode registers. A typical handler reads the status word, clears the bits it serviced by writing ones, and leaves the rest alone.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, enable reads 0, status reads 0, the mask register reads 0xFFF (all pins masked), both mode registers read 0, and the interrupt output is 0.
- R2: The word addresses are: 0 enable (read/write), 1 status (read only), 2 status clear, 3 mask set, 4 mask clear, 5 mask (read only), 6 mode low, 7 mode high. Register bits above bit 11 of enable, status and mask read as zero.
- R3: A pin's mode code is 3 bits wide: 0 falling edge, 1 rising edge, 2 low level, 3 high level, and any code with bit 2 set means both edges. Pin p (0..7) uses bits [4p+2:4p] of mode low. Pin p (8..11) uses bits [4(p-8)+2:4(p-8)] of mode high. Bit 3 of every slot, and the slots above pin 11, read as zero.
- R4: In an edge mode, the status bit of an enabled pin is set when the synchronized pin value makes the selected transition. The opposite transition does not set it.
- R5: In a level mode, the status bit of an enabled pin is set on every cycle that the selected level persists, so a clear written while the level is present leaves the bit at 1.
- R6: A pin whose enable bit is 0 never sets its status bit, whatever its mode and input.
- R7: Writing 1 to a bit of the status clear register clears that pin's status. Writing 0 leaves the bit unchanged.
- R8: Writing 1 to a mask set bit masks that pin, and writing 1 to a mask clear bit unmasks it. Zero bits leave the mask unchanged. The mask register returns the current mask.
- R9: The interrupt output is the registered OR over all pins of status AND enable AND NOT mask. It follows a change of its inputs one clock later.
- R10: When a new event and a status clear hit the same pin in the same cycle, the status bit ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pinIn | input | 12 | Asynchronous pin inputs |
| busAddr | input | 3 | Register word address |
| busWe | input | 1 | Write strobe, one write per cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| irqOut | output | 1 | Combined interrupt, active high |

## Verification
A wrong trigger decode or a wrong mode slot shows as a status bit that stays 0 after the selected transition, or one that sets on the opposite transition. Either is visible in the status word four clocks after the pin changes: two synchronizer stages, one status register and margin. A wrong mask or enable state shows as an interrupt output that differs from the expected value exactly one clock after the register write. A lost event in the clear/event collision shows as status reading 0 right after the colliding write.

// File: rtl/pin_event_irq_pkg.sv
package pin_event_irq_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_ENABLE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASKSET = 3'd3;
  localparam logic [ADDR_W-1:0] A_MASKCLR = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK    = 3'd5;
  localparam logic [ADDR_W-1:0] A_MODELO  = 3'd6;
  localparam logic [ADDR_W-1:0] A_MODEHI  = 3'd7;

  typedef struct packed {
    logic wrEnable;
    logic wrClear;
    logic wrMaskSet;
    logic wrMaskClr;
    logic wrModeLo;
    logic wrModeHi;
  } strobe_t;
endpackage

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pin_event_irq_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [NUM_PINS-1:0] enableQ,
  input  logic [NUM_PINS-1:0] statusQ,
  input  logic [NUM_PINS-1:0] maskQ,
  input  logic [DATA_W-1:0]   modeLoWord,
  input  logic [DATA_W-1:0]   modeHiWord,
  output strobe_t             strobes,
  output logic [DATA_W-1:0]   busRdata
);
  always_comb begin
    strobes           = '0;
    strobes.wrEnable  = busWe && (busAddr == A_ENABLE);
    strobes.wrClear   = busWe && (busAddr == A_CLEAR);
    strobes.wrMaskSet = busWe && (busAddr == A_MASKSET);
    strobes.wrMaskClr = busWe && (busAddr == A_MASKCLR);
    strobes.wrModeLo  = busWe && (busAddr == A_MODELO);
    strobes.wrModeHi  = busWe && (busAddr == A_MODEHI);
  end

  always_comb begin
    unique case (busAddr)
      A_ENABLE: busRdata = DATA_W'(enableQ);
      A_STATUS: busRdata = DATA_W'(statusQ);
      A_MASK:   busRdata = DATA_W'(maskQ);
      A_MODELO: busRdata = modeLoWord;
      A_MODEHI: busRdata = modeHiWord;
      default:  busRdata = '0;
    endcase
  end

  // R2: one address decodes to at most one write strobe
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));
endmodule

// File: rtl/pin_event_datapath.sv
module pin_event_datapath
  import pin_event_irq_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [DATA_W-1:0]   busWdata,
  input  strobe_t             strobes,
  output logic [NUM_PINS-1:0] enableQ,
  output logic [NUM_PINS-1:0] statusQ,
  output logic [NUM_PINS-1:0] maskQ,
  output logic [DATA_W-1:0]   modeLoWord,
  output logic [DATA_W-1:0]   modeHiWord,
  output logic                irqOut
);
  localparam int SLOTS = DATA_W / 4;
  localparam int MODE_W = 3;

  logic [NUM_PINS-1:0] syncA, syncB, syncPrev;
  logic [NUM_PINS-1:0] hitVec, clrBits;
  logic [MODE_W-1:0]   modeQ [NUM_PINS];

  assign clrBits = strobes.wrClear ? busWdata[NUM_PINS-1:0] : '0;

  // two-flop synchronizer and one-cycle history
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  // per-pin trigger decode
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_detect
    logic riseEv, fallEv, match;
    assign riseEv = syncB[p] & ~syncPrev[p];
    assign fallEv = ~syncB[p] & syncPrev[p];
    always_comb begin
      if (modeQ[p][2]) match = riseEv | fallEv;
      else begin
        unique case (modeQ[p][1:0])
          2'd0: match = fallEv;
          2'd1: match = riseEv;
          2'd2: match = ~syncB[p];
          default: match = syncB[p];
        endcase
      end
    end
    assign hitVec[p] = match & enableQ[p];
  end

  // mode registers
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (rst) modeQ[p] <= '0;
      else if ((p / SLOTS == 0) ? strobes.wrModeLo : strobes.wrModeHi)
        modeQ[p] <= busWdata[4*(p % SLOTS) +: MODE_W];
    end
  end

  always_comb begin
    modeLoWord = '0;
    modeHiWord = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (p / SLOTS == 0) modeLoWord[4*(p % SLOTS) +: MODE_W] = modeQ[p];
      else                modeHiWord[4*(p % SLOTS) +: MODE_W] = modeQ[p];
    end
  end

  // enable, status, mask, interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ <= '0;
      statusQ <= '0;
      maskQ   <= '1;
      irqOut  <= 1'b0;
    end else begin
      if (strobes.wrEnable) enableQ <= busWdata[NUM_PINS-1:0];
      statusQ <= (statusQ & ~clrBits) | hitVec;
      if (strobes.wrMaskSet) maskQ <= maskQ | busWdata[NUM_PINS-1:0];
      else if (strobes.wrMaskClr) maskQ <= maskQ & ~busWdata[NUM_PINS-1:0];
      irqOut <= |(statusQ & enableQ & ~maskQ);
    end
  end

  // R1: masks come out of reset all set
  assert_mask_reset_R1: assert property (@(posedge clk)
    rst |=> (&maskQ));
  // R6: with every pin disabled no status bit can rise
  assert_no_rise_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    (enableQ == '0) |=> ((statusQ & ~$past(statusQ)) == '0));
  // R9: all pins masked keeps the interrupt low on the next cycle
  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (&maskQ) |=> !irqOut);
  // R10: an event colliding with a clear leaves the bit set
  assert_event_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (|(clrBits & hitVec)) |=> ((statusQ & $past(clrBits & hitVec)) == $past(clrBits & hitVec)));
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_event_irq_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                irqOut
);
  strobe_t             strobes;
  logic [NUM_PINS-1:0] enableQ, statusQ, maskQ;
  logic [DATA_W-1:0]   modeLoWord, modeHiWord;

  pin_event_ctrl #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .enableQ(enableQ), .statusQ(statusQ), .maskQ(maskQ),
    .modeLoWord(modeLoWord), .modeHiWord(modeHiWord),
    .strobes(strobes), .busRdata(busRdata));

  pin_event_datapath #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .pinIn(pinIn), .busWdata(busWdata),
    .strobes(strobes), .enableQ(enableQ), .statusQ(statusQ),
    .maskQ(maskQ), .modeLoWord(modeLoWord), .modeHiWord(modeHiWord),
    .irqOut(irqOut));
endmodule

// File: tb/sim_pin_event_irq.sv
module sim_pin_event_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pinIn = '0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  int nChecks = 0;
  int nFails = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_irq u0 (.clk(clk), .rst(rst), .pinIn(pinIn), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut));

  // {mode[2:0], pin[3:0], startLevel, endLevel, expectStatus}
  localparam logic [9:0] VEC [10] = '{
    {3'd1, 4'd3,  1'b0, 1'b1, 1'b1},   // R4 rising seen
    {3'd1, 4'd3,  1'b1, 1'b0, 1'b0},   // R4 falling ignored in rise mode
    {3'd0, 4'd9,  1'b1, 1'b0, 1'b1},   // R4 falling seen
    {3'd0, 4'd9,  1'b0, 1'b1, 1'b0},   // R4 rising ignored in fall mode
    {3'd4, 4'd11, 1'b0, 1'b1, 1'b1},   // R4 both edges, rise
    {3'd6, 4'd11, 1'b1, 1'b0, 1'b1},   // R3 bit2 set means both, fall
    {3'd2, 4'd0,  1'b0, 1'b0, 1'b1},   // R5 low level persists
    {3'd2, 4'd5,  1'b1, 1'b1, 1'b0},   // R5 low mode, pin high
    {3'd3, 4'd8,  1'b1, 1'b1, 1'b1},   // R5 high level persists
    {3'd3, 4'd8,  1'b0, 1'b0, 1'b0}    // R5 high mode, pin low
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    waitCycles(3);
    rst = 1'b0;
    waitCycles(1);

    // R1 reset state
    rd(3'd0, rv); check("R1 enable", rv, 32'h0);
    rd(3'd1, rv); check("R1 status", rv, 32'h0);
    rd(3'd5, rv); check("R1 mask", rv, 32'hFFF);
    rd(3'd6, rv); check("R1 modelo", rv, 32'h0);
    rd(3'd7, rv); check("R1 modehi", rv, 32'h0);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R2 upper bits read zero
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, rv); check("R2 enable width", rv, 32'hFFF);
    wr(3'd0, 32'h0);
    // R3 slot layout
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, rv); check("R3 modelo slots", rv, 32'h7777_7777);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, rv); check("R3 modehi slots", rv, 32'h0000_7777);
    wr(3'd6, 32'h0); wr(3'd7, 32'h0);

    // table walk: R3 R4 R5
    for (int i = 0; i < 10; i++) begin
      logic [2:0] md;
      int pin;
      md = VEC[i][9:7];
      pin = int'(VEC[i][6:3]);
      wr(3'd6, 32'h0); wr(3'd7, 32'h0);
      wr((pin < 8) ? 3'd6 : 3'd7, 32'(md) << (4 * (pin % 8)));
      wr(3'd0, 32'h1 << pin);
      pinIn = '0;
      pinIn[pin] = VEC[i][2];
      waitCycles(4);
      wr(3'd2, 32'hFFF);
      pinIn[pin] = VEC[i][1];
      waitCycles(4);
      rd(3'd1, rv);
      check($sformatf("R4/R5 vector %0d", i), {31'b0, rv[pin]}, {31'b0, VEC[i][0]});
    end
    wr(3'd0, 32'h0); wr(3'd2, 32'hFFF);
    wr(3'd6, 32'h0); wr(3'd7, 32'h0);
    pinIn = '0;

    // R6 disabled pin ignores edges
    wr(3'd6, 32'h1 << 16);          // pin 4 rising
    waitCycles(2);
    pinIn[4] = 1'b1;
    waitCycles(5);
    rd(3'd1, rv); check("R6 disabled", rv, 32'h0);
    pinIn = '0;
    waitCycles(3);

    // R7 status clear: zero leaves bit, one clears it
    wr(3'd6, 32'h1 << 12);          // pin 3 rising
    wr(3'd0, 32'h8);
    pinIn[3] = 1'b1; waitCycles(4);
    pinIn[3] = 1'b0; waitCycles(4);
    wr(3'd2, 32'h0);
    rd(3'd1, rv); check("R7 write zero", rv, 32'h8);

    // R10 event wins over clear in the same cycle
    pinIn[3] = 1'b1;
    waitCycles(2);
    busAddr = 3'd2; busWdata = 32'h8; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
    rd(3'd1, rv); check("R10 collision", rv, 32'h8);

    // R8 / R9 mask and interrupt latency
    waitCycles(2);
    check("R8 masked irq", {31'b0, irqOut}, 32'h0);
    wr(3'd4, 32'h8);
    rd(3'd5, rv); check("R8 mask clear", rv, 32'hFF7);
    check("R9 latency low", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    check("R9 irq high", {31'b0, irqOut}, 32'h1);
    wr(3'd3, 32'h8);
    rd(3'd5, rv); check("R8 mask set", rv, 32'hFFF);
    @(negedge clk);
    check("R9 irq drops", {31'b0, irqOut}, 32'h0);

    // R7 write one clears
    wr(3'd2, 32'h8);
    rd(3'd1, rv); check("R7 write one", rv, 32'h0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule